// File: doc/BRIEF.md
# Planar Write Data Path with Colour Expansion

This block forms the data and the per-bit update masks for one processor write to a four-plane video memory. It takes the processor byte, rotates it right by a programmable count, and then produces one data byte per plane according to a write-mode field. The modes are plain pass-through of the rotated byte, expansion of a one-bit-per-pixel bitmap into two four-bit colours, and substitution of per-plane dither latches. A separate masked-write control picks which bit positions of each plane may change in memory. The mask comes either from a mask register or from the rotated processor byte, and a plane-enable input gates it per plane.

The results are registered. A write strobe captures the inputs, and one clock later the packed data bus, the packed mask bus and a one-cycle valid pulse appear. Downstream logic merges them with the existing memory contents. Plane p always occupies bits [8p+7:8p] of both packed buses. The standard arithmetic and set/reset stages are not part of this block: the standard mode stands for their output by passing the rotated byte through.

Top module: `planar_wr_path`

## Requirements
- R1: After reset, outValid is 0 and planeData and planeMask are all zero.
- R2: When wrEn is high at a rising edge, the results for the inputs present at that edge appear after that edge and outValid is 1 for that one cycle. When wrEn is low, outValid is 0 after the edge and planeData and planeMask keep their previous values.
- R3: The processor byte is rotated right by rotCount, so result bit i is cpuByte[(i+rotCount) mod 8], before it is used as data, as expansion source or as mask.
- R4: With modeSel 0 (standard) or 3 (invalid, treated as standard), every plane's data byte equals the rotated byte.
- R5: With modeSel 1 (colour expansion), bit i of plane p is fgColor[p] where source bit i is 1, and bgColor[p] where it is 0.
- R6: In colour expansion the source is the rotated byte when srcIsCpu is 1, and patternReg when it is 0.
- R7: With modeSel 2 (dither), plane p's data byte equals fgLatch[8p+7:8p], regardless of the processor byte.
- R8: With maskEn 0, plane p's mask byte is 8'hFF if planeEnable[p] is 1 and 8'h00 if it is 0.
- R9: With maskEn 1, plane p's mask byte is the chosen mask ANDed with planeEnable[p]. The chosen mask is the rotated byte when maskFromCpu is 1, and maskReg when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Captures one write |
| cpuByte | input | 8 | Processor write byte |
| rotCount | input | 3 | Right-rotate amount |
| modeSel | input | 2 | 0 standard, 1 expansion, 2 dither, 3 as standard |
| srcIsCpu | input | 1 | Expansion source: 1 rotated byte, 0 pattern |
| patternReg | input | 8 | Expansion pattern |
| fgColor | input | 4 | Foreground colour, bit p to plane p |
| bgColor | input | 4 | Background colour, bit p to plane p |
| fgLatch | input | 32 | Dither latches, plane p in [8p+7:8p] |
| maskEn | input | 1 | Masked writes on |
| maskFromCpu | input | 1 | Mask source: 1 rotated byte, 0 maskReg |
| maskReg | input | 8 | Mask register |
| planeEnable | input | 4 | Per-plane write enable |
| outValid | output | 1 | Result valid pulse |
| planeData | output | 32 | Per-plane data, plane p in [8p+7:8p] |
| planeMask | output | 32 | Per-plane update mask, plane p in [8p+7:8p] |

## Verification
The colour expansion and the masked write can both draw on the same rotated processor byte in one write: once as the bitmap and once as the mask. The bench provokes this with modeSel 1, srcIsCpu 1, maskEn 1, maskFromCpu 1 and a nonzero rotate count. It also mixes the modes with random settings. In every cycle it compares both buses against a behavioural model, so a wrong rotation or a swapped source shows up as a mismatch in the data, in the mask, or in both.

// File: rtl/planar_wr_pkg.sv
package planar_wr_pkg;
  typedef enum logic [1:0] {
    MODE_STD    = 2'd0,
    MODE_EXPAND = 2'd1,
    MODE_DITHER = 2'd2,
    MODE_RSVD   = 2'd3
  } wrMode_e;

  typedef struct packed {
    logic load;
    logic expand;
    logic dither;
    logic cpuSrc;
    logic maskOn;
    logic maskCpu;
  } wrStrobes_t;
endpackage

// File: rtl/planar_wr_ctrl.sv
module planar_wr_ctrl
  import planar_wr_pkg::*;
(
  input  logic       wrEn,
  input  logic [1:0] modeSel,
  input  logic       srcIsCpu,
  input  logic       maskEn,
  input  logic       maskFromCpu,
  output wrStrobes_t strobes
);
  wrMode_e mode;
  assign mode = wrMode_e'(modeSel);

  always_comb begin
    strobes         = '0;
    strobes.load    = wrEn;
    strobes.cpuSrc  = srcIsCpu;
    strobes.maskOn  = maskEn;
    strobes.maskCpu = maskFromCpu;
    unique case (mode)
      MODE_EXPAND: strobes.expand = 1'b1;
      MODE_DITHER: strobes.dither = 1'b1;
      default:     ;
    endcase
  end
endmodule

// File: rtl/planar_wr_datapath.sv
module planar_wr_datapath
  import planar_wr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PLANES = 4,
  localparam int ROT_W = $clog2(DATA_W),
  localparam int BUS_W = DATA_W * PLANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobes_t        strobes,
  input  logic [DATA_W-1:0] cpuByte,
  input  logic [ROT_W-1:0]  rotCount,
  input  logic [DATA_W-1:0] patternReg,
  input  logic [PLANES-1:0] fgColor,
  input  logic [PLANES-1:0] bgColor,
  input  logic [BUS_W-1:0]  fgLatch,
  input  logic [DATA_W-1:0] maskReg,
  input  logic [PLANES-1:0] planeEnable,
  output logic              outValid,
  output logic [BUS_W-1:0]  planeData,
  output logic [BUS_W-1:0]  planeMask
);
  logic [2*DATA_W-1:0] doubled;
  logic [DATA_W-1:0]   rotByte;
  logic [DATA_W-1:0]   expSrc;
  logic [DATA_W-1:0]   bitMask;
  logic [BUS_W-1:0]    nextData;
  logic [BUS_W-1:0]    nextMask;

  assign doubled = {cpuByte, cpuByte} >> rotCount;
  assign rotByte = doubled[DATA_W-1:0];
  assign expSrc  = strobes.cpuSrc ? rotByte : patternReg;
  assign bitMask = !strobes.maskOn ? {DATA_W{1'b1}}
                 : (strobes.maskCpu ? rotByte : maskReg);

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    logic [DATA_W-1:0] expanded;
    assign expanded = (expSrc & {DATA_W{fgColor[p]}}) |
                      (~expSrc & {DATA_W{bgColor[p]}});

    always_comb begin
      if (strobes.dither)
        nextData[p*DATA_W +: DATA_W] = fgLatch[p*DATA_W +: DATA_W];
      else if (strobes.expand)
        nextData[p*DATA_W +: DATA_W] = expanded;
      else
        nextData[p*DATA_W +: DATA_W] = rotByte;
    end

    assign nextMask[p*DATA_W +: DATA_W] = bitMask & {DATA_W{planeEnable[p]}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      planeData <= '0;
      planeMask <= '0;
    end else begin
      outValid <= strobes.load;
      if (strobes.load) begin
        planeData <= nextData;
        planeMask <= nextMask;
      end
    end
  end
endmodule

// File: rtl/planar_wr_path.sv
module planar_wr_path
  import planar_wr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PLANES = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [DATA_W-1:0]          cpuByte,
  input  logic [$clog2(DATA_W)-1:0]  rotCount,
  input  logic [1:0]                 modeSel,
  input  logic                       srcIsCpu,
  input  logic [DATA_W-1:0]          patternReg,
  input  logic [PLANES-1:0]          fgColor,
  input  logic [PLANES-1:0]          bgColor,
  input  logic [DATA_W*PLANES-1:0]   fgLatch,
  input  logic                       maskEn,
  input  logic                       maskFromCpu,
  input  logic [DATA_W-1:0]          maskReg,
  input  logic [PLANES-1:0]          planeEnable,
  output logic                       outValid,
  output logic [DATA_W*PLANES-1:0]   planeData,
  output logic [DATA_W*PLANES-1:0]   planeMask
);
  wrStrobes_t strobes;

  planar_wr_ctrl u_ctrl (
    .wrEn        (wrEn),
    .modeSel     (modeSel),
    .srcIsCpu    (srcIsCpu),
    .maskEn      (maskEn),
    .maskFromCpu (maskFromCpu),
    .strobes     (strobes)
  );

  planar_wr_datapath #(.DATA_W(DATA_W), .PLANES(PLANES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .cpuByte     (cpuByte),
    .rotCount    (rotCount),
    .patternReg  (patternReg),
    .fgColor     (fgColor),
    .bgColor     (bgColor),
    .fgLatch     (fgLatch),
    .maskReg     (maskReg),
    .planeEnable (planeEnable),
    .outValid    (outValid),
    .planeData   (planeData),
    .planeMask   (planeMask)
  );
endmodule

// File: rtl/planar_wr_path_chk.sv
module planar_wr_path_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [7:0]  cpuByte,
  input logic [2:0]  rotCount,
  input logic [1:0]  modeSel,
  input logic        srcIsCpu,
  input logic [3:0]  fgColor,
  input logic [3:0]  bgColor,
  input logic [31:0] fgLatch,
  input logic        maskEn,
  input logic [3:0]  planeEnable,
  input logic        outValid,
  input logic [31:0] planeData,
  input logic [31:0] planeMask
);
  a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> outValid);

  a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> !outValid);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(planeData) && $stable(planeMask)));

  a_r4_std_unrotated: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && modeSel == 2'd0 && rotCount == 3'd0)
      |=> planeData == {4{$past(cpuByte)}});

  a_r7_dither_latch: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && modeSel == 2'd2) |=> planeData == $past(fgLatch));

  a_r5_expand_solid_fg: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && modeSel == 2'd1 && srcIsCpu && rotCount == 3'd0 &&
     fgColor == 4'hF && bgColor == 4'h0)
      |=> planeData == {4{$past(cpuByte)}});

  a_r8_full_mask: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !maskEn && planeEnable == 4'hF) |=> planeMask == 32'hFFFF_FFFF);

  a_r9_plane0_off: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !planeEnable[0]) |=> planeMask[7:0] == 8'h00);
endmodule

bind planar_wr_path planar_wr_path_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .wrEn        (wrEn),
  .cpuByte     (cpuByte),
  .rotCount    (rotCount),
  .modeSel     (modeSel),
  .srcIsCpu    (srcIsCpu),
  .fgColor     (fgColor),
  .bgColor     (bgColor),
  .fgLatch     (fgLatch),
  .maskEn      (maskEn),
  .planeEnable (planeEnable),
  .outValid    (outValid),
  .planeData   (planeData),
  .planeMask   (planeMask)
);

// File: tb/planar_wr_path_tb.sv
module planar_wr_path_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [7:0]  cpuByte;
  logic [2:0]  rotCount;
  logic [1:0]  modeSel;
  logic        srcIsCpu;
  logic [7:0]  patternReg;
  logic [3:0]  fgColor;
  logic [3:0]  bgColor;
  logic [31:0] fgLatch;
  logic        maskEn;
  logic        maskFromCpu;
  logic [7:0]  maskReg;
  logic [3:0]  planeEnable;
  logic        outValid;
  logic [31:0] planeData;
  logic [31:0] planeMask;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic        expValid;
  logic [31:0] expData;
  logic [31:0] expMask;
  string       dataTag;
  string       maskTag;

  always #4 clk = ~clk;

  planar_wr_path dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .cpuByte(cpuByte),
    .rotCount(rotCount), .modeSel(modeSel), .srcIsCpu(srcIsCpu),
    .patternReg(patternReg), .fgColor(fgColor), .bgColor(bgColor),
    .fgLatch(fgLatch), .maskEn(maskEn), .maskFromCpu(maskFromCpu),
    .maskReg(maskReg), .planeEnable(planeEnable), .outValid(outValid),
    .planeData(planeData), .planeMask(planeMask)
  );

  function automatic logic [7:0] rotr(input logic [7:0] x, input int r);
    logic [7:0] y;
    for (int i = 0; i < 8; i++) y[i] = x[(i + r) % 8];
    return y;
  endfunction

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    check("R2 outValid", {31'd0, outValid}, {31'd0, expValid});
    check(dataTag, planeData, expData);
    check(maskTag, planeMask, expMask);
  endtask

  // Model of one capture, computed from the requirements.
  task automatic predict();
    logic [7:0] r;
    logic [7:0] src;
    logic [7:0] m;
    expValid = wrEn;
    if (!wrEn) begin
      dataTag = "R2 hold data";
      maskTag = "R2 hold mask";
      return;
    end
    r = rotr(cpuByte, int'(rotCount));           // R3
    src = srcIsCpu ? r : patternReg;             // R6
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 8; i++) begin
        case (modeSel)
          2'd1: expData[p*8+i] = src[i] ? fgColor[p] : bgColor[p];  // R5
          2'd2: expData[p*8+i] = fgLatch[p*8+i];                     // R7
          default: expData[p*8+i] = r[i];                            // R4
        endcase
      end
    end
    m = maskEn ? (maskFromCpu ? r : maskReg) : 8'hFF;
    for (int p = 0; p < 4; p++)
      expMask[p*8 +: 8] = planeEnable[p] ? m : 8'h00;
    case (modeSel)
      2'd1: dataTag = srcIsCpu ? "R5/R6 expand cpu src (R3 rotate)" : "R5/R6 expand pattern";
      2'd2: dataTag = "R7 dither";
      default: dataTag = "R4 standard (R3 rotate)";
    endcase
    maskTag = maskEn ? "R9 masked write" : "R8 unmasked plane enable";
  endtask

  // Drive at negedge, then model what the next rising edge will capture.
  task automatic step(input logic we, input logic [7:0] cb, input int rc,
                      input logic [1:0] md, input logic sc, input logic [7:0] pat,
                      input logic [3:0] fg, input logic [3:0] bg,
                      input logic [31:0] lat, input logic me, input logic mc,
                      input logic [7:0] mr, input logic [3:0] pe);
    @(negedge clk);
    compareAll();
    wrEn = we; cpuByte = cb; rotCount = 3'(rc); modeSel = md; srcIsCpu = sc;
    patternReg = pat; fgColor = fg; bgColor = bg; fgLatch = lat;
    maskEn = me; maskFromCpu = mc; maskReg = mr; planeEnable = pe;
    predict();
  endtask

  initial begin
    rstN = 1'b0; wrEn = 1'b0; cpuByte = '0; rotCount = '0; modeSel = '0;
    srcIsCpu = 1'b0; patternReg = '0; fgColor = '0; bgColor = '0;
    fgLatch = '0; maskEn = 1'b0; maskFromCpu = 1'b0; maskReg = '0;
    planeEnable = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 reset valid", {31'd0, outValid}, 32'd0);
    check("R1 reset data", planeData, 32'd0);
    check("R1 reset mask", planeMask, 32'd0);
    rstN = 1'b1;
    expValid = 1'b0; expData = '0; expMask = '0;
    dataTag = "R2 hold data"; maskTag = "R2 hold mask";

    // R4 standard, no rotation, all planes
    step(1, 8'hA5, 0, 2'd0, 0, 8'h00, 4'h0, 4'h0, 32'h0, 0, 0, 8'h00, 4'hF);
    // R3 rotate right by 3
    step(1, 8'h81, 3, 2'd0, 0, 8'h00, 4'h0, 4'h0, 32'h0, 0, 0, 8'h00, 4'hF);
    // R4 mode 3 acts as standard
    step(1, 8'h3C, 1, 2'd3, 0, 8'h00, 4'h0, 4'h0, 32'h0, 0, 0, 8'h00, 4'h5);
    // R2 idle: outputs hold
    step(0, 8'hFF, 7, 2'd2, 1, 8'hFF, 4'hF, 4'hF, 32'hDEADBEEF, 1, 1, 8'h00, 4'h0);
    step(0, 8'h00, 0, 2'd1, 0, 8'h0F, 4'hA, 4'h5, 32'h0, 0, 0, 8'h00, 4'hF);
    // R5/R6 expansion from pattern register
    step(1, 8'hFF, 0, 2'd1, 0, 8'hF0, 4'hA, 4'h5, 32'h0, 0, 0, 8'h00, 4'hF);
    // R5/R6 expansion from CPU byte, rotated
    step(1, 8'h0F, 2, 2'd1, 1, 8'h00, 4'h6, 4'h9, 32'h0, 0, 0, 8'h00, 4'hF);
    // R7 dither ignores CPU byte
    step(1, 8'h55, 5, 2'd2, 1, 8'h00, 4'h0, 4'h0, 32'h12345678, 0, 0, 8'h00, 4'hF);
    // R9 mask register, partial plane enable
    step(1, 8'h77, 0, 2'd0, 0, 8'h00, 4'h0, 4'h0, 32'h0, 1, 0, 8'hC3, 4'h6);
    // R8 unmasked, plane enable gating only
    step(1, 8'h77, 0, 2'd0, 0, 8'h00, 4'h0, 4'h0, 32'h0, 0, 1, 8'hC3, 4'h9);
    // Same cycle: expansion and mask both from the rotated CPU byte (R3, R5, R6, R9)
    step(1, 8'h96, 4, 2'd1, 1, 8'h00, 4'hC, 4'h3, 32'h0, 1, 1, 8'h00, 4'hF);
    step(1, 8'h01, 7, 2'd1, 1, 8'hAA, 4'hF, 4'h0, 32'h0, 1, 1, 8'h55, 4'hB);
    // Random mix
    for (int k = 0; k < 400; k++) begin
      step(1'($urandom), 8'($urandom), int'($urandom % 8), 2'($urandom),
           1'($urandom), 8'($urandom), 4'($urandom), 4'($urandom),
           32'($urandom), 1'($urandom), 1'($urandom), 8'($urandom),
           4'($urandom));
    end
    step(0, 8'h00, 0, 2'd0, 0, 8'h00, 4'h0, 4'h0, 32'h0, 0, 0, 8'h00, 4'h0);
    @(negedge clk);
    compareAll();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule